// File: doc/BRIEF.md
# Capture-Reset Interval Timer

This block is a 32-bit up-counter that runs on the system clock and is programmed through a small word-addressed register port. Software selects one of four run modes: stopped, single pass, free-running wrap, or free-running wrap with a new period taken from a shadow register at every wrap. Each time the counter equals the period, one interrupt pulse is raised and a sticky status flag is set.

Two optional behaviours change how the counter is cleared. In the free-running modes, an external pin can be armed so that a chosen transition on it restarts the count from zero and raises an interrupt. Separately, the count register can be set to clear itself whenever it is read, which raises no event.

Register map (word addresses): 0 control, 1 period, 2 reload, 3 count, 4 status. Control bits: [1:0] run mode, [3:2] pin edge select, [4] pin capture arm, [5] clear-on-read. Status bits: [0] period hit, [1] pin capture.

Top module: `cap_timer`

## Requirements
- R1: After reset the control, period, reload, count and status registers read 0 and `irq_o` is low.
- R2: With run mode 0 the count holds its value; a write to address 3 still loads it.
- R3: With run mode 1 the count rises to the period, stays there, the run-mode field returns to 0 on its own, and exactly one interrupt cycle is raised.
- R4: With run mode 2 the count goes 0, 1, ..., P, then 0 in the cycle after it equalled P, and keeps going; each hit raises `irq_o` for one cycle and sets status bit 0.
- R5: With run mode 3 the count wraps as in R4 and, at the same wrap, the period register takes the reload register's value.
- R6: Edge select 0 reacts to a rising pin, 1 to a falling pin, 2 to both, 3 to neither.
- R7: A selected pin edge acts only when control bit 4 is 1 and the run mode is 2 or 3; it clears the count, sets status bit 1 and raises `irq_o`.
- R8: With control bit 5 set, a read of address 3 returns the count and clears it, with no interrupt and no status change.
- R9: A read-clear that coincides with a period hit returns the unreduced value, clears the count, and still raises the hit interrupt and status bit 0.
- R10: Status bits are cleared by writing 1 to them; writing 0 leaves them; `irq_o` high always comes with a set status bit.
- R11: Changing the run mode never clears the count.
- R12: A pin change driven between edges clears the count at the third rising clock edge after it (two synchronizer stages plus edge detection).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_rd_i | input | 1 | Register read strobe, one cycle per read |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| irq_o | output | 1 | Interrupt pulse, one cycle per event |

## Verification
The assertions assume the register port carries at most one write to the count register per cycle and that read and write strobes are single-cycle, which is the only use the register port allows; the stimulus drives each access for exactly one clock and keeps strobes low between accesses. The pin is assumed to hold each level for at least three clock cycles so that no edge is lost inside the synchronizer, and the stimulus always waits several cycles between pin changes. Periods are chosen so that no unplanned hit falls inside a capture window being measured.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic [1:0] {
    RUN_OFF    = 2'd0,
    RUN_ONCE   = 2'd1,
    RUN_LOOP   = 2'd2,
    RUN_RELOAD = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_sel_e;

  // Packed LSB-first: run [1:0], edge_sel [3:2], cap_en [4], clr_on_rd [5]
  typedef struct packed {
    logic      clr_on_rd;
    logic      cap_en;
    edge_sel_e edge_sel;
    run_mode_e run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STAT_W = 2;

  localparam int A_CTRL = 0;
  localparam int A_PRD  = 1;
  localparam int A_RLD  = 2;
  localparam int A_CNT  = 3;
  localparam int A_STAT = 4;

endpackage

// File: rtl/cap_timer_edge.sv
module cap_timer_edge
  import cap_timer_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  edge_sel_e edge_sel_i,
  input  logic      arm_i,
  output logic      evt_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              lvl;
  logic              rise;
  logic              fall;
  logic              raw;

  for (genvar s = 0; s < STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= lvl;
  end

  assign rise = lvl & ~last_q;
  assign fall = ~lvl & last_q;

  always_comb begin
    case (edge_sel_i)
      EDGE_RISE: raw = rise;
      EDGE_FALL: raw = fall;
      EDGE_BOTH: raw = rise | fall;
      default:   raw = 1'b0;
    endcase
  end

  assign evt_o = arm_i & raw;

  // R6: no event when the edge selector is the reserved code
  p_no_reserved_evt_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == EDGE_NONE) |-> !evt_o);

endmodule

// File: rtl/cap_timer_counter.sv
module cap_timer_counter
  import cap_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  run_mode_e     run_i,
  input  logic [DW-1:0] prd_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_clr_i,
  input  logic          cap_i,
  output logic [DW-1:0] cnt_o,
  output logic          hit_o
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic          active;

  assign active = (run_i != RUN_OFF);
  assign hit_o  = active && (cnt_q == prd_i);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en_i) begin
      cnt_d = wr_data_i;
    end else if (cap_i || rd_clr_i) begin
      cnt_d = '0;
    end else if (hit_o) begin
      cnt_d = (run_i == RUN_ONCE) ? cnt_q : '0;
    end else if (active) begin
      cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_hold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i == RUN_OFF && !wr_en_i && !rd_clr_i && !cap_i) |=> (cnt_q == $past(cnt_q)));

  p_oneshot_stop_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i == RUN_ONCE && hit_o && !wr_en_i && !cap_i && !rd_clr_i) |=> (cnt_q == $past(cnt_q)));

  p_wrap_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i[1] && hit_o && !wr_en_i) |=> (cnt_q == '0));

  p_cap_clear_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !wr_en_i) |=> (cnt_q == '0));

  p_rd_clear_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !wr_en_i) |=> (cnt_q == '0));

endmodule

// File: rtl/cap_timer_regs.sv
module cap_timer_regs
  import cap_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic [DW-1:0] cnt_i,
  input  logic          hit_i,
  input  logic          cap_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] prd_o,
  output logic          cnt_wr_o,
  output logic          rd_clr_o,
  output logic          irq_o
);

  ctrl_t             ctrl_q;
  logic [DW-1:0]     prd_q;
  logic [DW-1:0]     rld_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_clr;
  logic              irq_q;
  logic              wr_ctrl, wr_prd, wr_rld, wr_stat;

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == AW'(A_CTRL));
  assign wr_prd   = reg_wr_i && (reg_addr_i == AW'(A_PRD));
  assign wr_rld   = reg_wr_i && (reg_addr_i == AW'(A_RLD));
  assign wr_stat  = reg_wr_i && (reg_addr_i == AW'(A_STAT));
  assign cnt_wr_o = reg_wr_i && (reg_addr_i == AW'(A_CNT));
  assign rd_clr_o = reg_rd_i && (reg_addr_i == AW'(A_CNT)) && ctrl_q.clr_on_rd;
  assign stat_clr = wr_stat ? reg_wdata_i[STAT_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end else if (hit_i && ctrl_q.run == RUN_ONCE) begin
      ctrl_q.run <= RUN_OFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q <= '0;
    end else if (wr_prd) begin
      prd_q <= reg_wdata_i;
    end else if (hit_i && ctrl_q.run == RUN_RELOAD) begin
      prd_q <= rld_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rld_q <= '0;
    else if (wr_rld) rld_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | {cap_i, hit_i};
      irq_q  <= hit_i | cap_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(A_CTRL): reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      AW'(A_PRD):  reg_rdata_o = prd_q;
      AW'(A_RLD):  reg_rdata_o = rld_q;
      AW'(A_CNT):  reg_rdata_o = cnt_i;
      AW'(A_STAT): reg_rdata_o[STAT_W-1:0] = stat_q;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign prd_o  = prd_q;
  assign irq_o  = irq_q;

  p_oneshot_off_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ctrl_q.run == RUN_ONCE && !wr_ctrl) |=> (ctrl_q.run == RUN_OFF));

  p_reload_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && ctrl_q.run == RUN_RELOAD && !wr_prd) |=> (prd_q == $past(rld_q)));

  p_hit_flag_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (stat_q[0] && irq_q));

  p_irq_flag_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (stat_q != '0));

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          cap_pin_i,
  output logic          irq_o
);

  ctrl_t         ctrl;
  logic [DW-1:0] prd;
  logic [DW-1:0] cnt;
  logic          cnt_wr;
  logic          rd_clr;
  logic          hit;
  logic          cap_evt;
  logic          cap_arm;

  // capture only in the two free-running modes
  assign cap_arm = ctrl.cap_en && ctrl.run[1];

  cap_timer_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cnt_i       (cnt),
    .hit_i       (hit),
    .cap_i       (cap_evt),
    .ctrl_o      (ctrl),
    .prd_o       (prd),
    .cnt_wr_o    (cnt_wr),
    .rd_clr_o    (rd_clr),
    .irq_o       (irq_o)
  );

  cap_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (cap_pin_i),
    .edge_sel_i (ctrl.edge_sel),
    .arm_i      (cap_arm),
    .evt_o      (cap_evt)
  );

  cap_timer_counter #(.DW(DW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl.run),
    .prd_i     (prd),
    .wr_en_i   (cnt_wr),
    .wr_data_i (reg_wdata_i),
    .rd_clr_i  (rd_clr),
    .cap_i     (cap_evt),
    .cnt_o     (cnt),
    .hit_o     (hit)
  );

  p_cap_gate_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.cap_en || !ctrl.run[1]) |-> !cap_evt);

endmodule

// File: tb/cap_timer_tb_top.sv
module cap_timer_tb_top;

  localparam int CLK_P = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_PRD = 3'd1, A_RLD = 3'd2,
                         A_CNT  = 3'd3, A_STAT = 3'd4;

  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cap_pin, irq;

  int total = 0;
  int bad   = 0;
  int irq_cnt = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  cap_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cap_pin_i(cap_pin), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver tasks: entered at a falling edge, leave at the next one
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: samples a quarter period after each falling edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (irq === 1'b1) irq_cnt++;
    if (reg_rd === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk("monitor read without expectation", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, reg_rdata, e);
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; cap_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_PRD,  0, "R1 period");
    rd(A_CNT,  0, "R1 count");
    rd(A_STAT, 0, "R1 status");

    // R2 stopped counter holds, write still loads
    wr(A_CNT, 7);
    idle(3);
    rd(A_CNT, 7, "R2 hold a");
    rd(A_CNT, 7, "R2 hold b");

    // R4 free-running wrap
    wr(A_PRD, 4);
    wr(A_CNT, 0);
    irq_cnt = 0;
    wr(A_CTRL, 2);
    for (int i = 0; i < 7; i++) rd(A_CNT, (i <= 4) ? i : i - 5, "R4 wrap seq");
    wr(A_CTRL, 0);
    chk("R4 one irq per wrap", irq_cnt, 1);
    rd(A_STAT, 1, "R4 hit flag");
    rd(A_CNT, 3, "R11 mode change keeps count");
    wr(A_STAT, 0);
    rd(A_STAT, 1, "R10 write 0 keeps flag");
    wr(A_STAT, 1);
    rd(A_STAT, 0, "R10 write 1 clears flag");

    // R5 reload at wrap
    wr(A_CNT, 0);
    wr(A_RLD, 5);
    wr(A_PRD, 2);
    wr(A_CTRL, 3);
    rd(A_CNT, 0, "R5 seq"); rd(A_CNT, 1, "R5 seq"); rd(A_CNT, 2, "R5 seq");
    for (int i = 0; i < 7; i++) rd(A_CNT, (i <= 5) ? i : 0, "R5 seq after reload");
    wr(A_CTRL, 0);
    rd(A_PRD, 5, "R5 period reloaded");

    // R3 one-shot
    wr(A_CNT, 0);
    wr(A_PRD, 3);
    wr(A_STAT, 3);
    irq_cnt = 0;
    wr(A_CTRL, 1);
    for (int i = 0; i < 6; i++) rd(A_CNT, (i <= 3) ? i : 3, "R3 oneshot seq");
    rd(A_CTRL, 0, "R3 run field cleared");
    chk("R3 single irq", irq_cnt, 1);

    // R11 direct count load while running, restart keeps count
    wr(A_PRD, 100);
    wr(A_CNT, 0);
    wr(A_CTRL, 2);
    idle(2);
    wr(A_CNT, 50);
    rd(A_CNT, 50, "R11 load while running");
    rd(A_CNT, 51, "R11 continues");
    wr(A_CTRL, 0);
    wr(A_CTRL, 2);
    rd(A_CNT, 53, "R11 restart keeps count");

    // R8 clear on read, no event
    wr(A_CTRL, 0);
    wr(A_CNT, 0);
    wr(A_STAT, 3);
    irq_cnt = 0;
    wr(A_CTRL, 34);
    idle(3);
    rd(A_CNT, 3, "R8 read returns value");
    rd(A_CNT, 0, "R8 cleared by read");
    idle(2);
    rd(A_CNT, 2, "R8 counts on");
    rd(A_STAT, 0, "R8 no status");
    chk("R8 no irq", irq_cnt, 0);

    // R9 read-clear coinciding with hit
    wr(A_CTRL, 0);
    wr(A_CNT, 0);
    wr(A_PRD, 3);
    wr(A_STAT, 3);
    irq_cnt = 0;
    wr(A_CTRL, 34);
    idle(3);
    rd(A_CNT, 3, "R9 pre-clear value");
    rd(A_CNT, 0, "R9 cleared");
    wr(A_CTRL, 0);
    rd(A_STAT, 1, "R9 hit flag kept");
    chk("R9 irq raised", irq_cnt, 1);

    // R7/R12 rising-edge capture
    wr(A_CNT, 0);
    wr(A_PRD, 1000);
    wr(A_STAT, 3);
    wr(A_CTRL, 18);
    idle(5);
    cap_pin = 1'b1;
    idle(3);
    rd(A_CNT, 0, "R12 cleared at third edge");
    rd(A_STAT, 2, "R7 capture flag");
    wr(A_STAT, 2);

    // R6 fall ignored with rise select, rise ignored with fall select
    cap_pin = 1'b0;
    idle(4);
    rd(A_STAT, 0, "R6 fall ignored on rise select");
    wr(A_CTRL, 22);
    cap_pin = 1'b1;
    idle(4);
    rd(A_STAT, 0, "R6 rise ignored on fall select");
    cap_pin = 1'b0;
    idle(3);
    rd(A_CNT, 0, "R6 fall captured");
    rd(A_STAT, 2, "R6 fall flag");
    wr(A_STAT, 3);

    // R6 both edges
    irq_cnt = 0;
    wr(A_CTRL, 26);
    cap_pin = 1'b1; idle(6);
    cap_pin = 1'b0; idle(6);
    chk("R6 both edges two irqs", irq_cnt, 2);
    wr(A_STAT, 3);

    // R6 reserved selector
    irq_cnt = 0;
    wr(A_CTRL, 30);
    cap_pin = 1'b1; idle(6);
    cap_pin = 1'b0; idle(6);
    chk("R6 reserved no irq", irq_cnt, 0);
    rd(A_STAT, 0, "R6 reserved no flag");

    // R7 gating: one-shot mode, and arm bit clear
    wr(A_CNT, 0);
    wr(A_CTRL, 17);
    cap_pin = 1'b1; idle(5);
    rd(A_STAT, 0, "R7 no capture in oneshot");
    cap_pin = 1'b0; idle(5);
    wr(A_CTRL, 2);
    cap_pin = 1'b1; idle(5);
    cap_pin = 1'b0; idle(5);
    rd(A_STAT, 0, "R7 no capture when unarmed");
    wr(A_CTRL, 0);

    idle(2);
    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule